// File: doc/BRIEF.md
# Single-Precision Round and Pack Unit

This block finishes a single-precision floating-point operation. It takes the sign, a signed unbiased exponent and a 27-bit working significand. In that significand, bit 26 is the hidden one, bits 25..3 are the fraction, and bits 2..0 carry guard, round and sticky information. The block rounds the value under one of four directions, handles results that are too small or too large, and returns a packed 32-bit IEEE-754 word with inexact, underflow and overflow flags.

A value below the smallest normal exponent is shifted right with sticky collection to form a subnormal. When flushing is enabled, such a value is replaced by zero or by the smallest subnormal, depending on the direction and the sign. An exponent of -127 whose rounding carries out is treated as the smallest normal number rather than as a tiny value. Overflowed results become infinity or the largest finite number, chosen from the direction and the sign.

The result is registered. A control machine has two states. **ST_IDLE** means no result is presented. **ST_EMIT** means the word and flags captured at the last edge are valid. The machine has three transitions:
- **T_ACCEPT**: ST_IDLE to ST_EMIT when in_valid is high.
- **T_STREAM**: ST_EMIT to ST_EMIT when in_valid is high.
- **T_DRAIN**: ST_EMIT to ST_IDLE when in_valid is low.

Top module: `sp_round_pack`

## Requirements
- R1: A result is presented, with out_valid high, exactly one cycle after in_valid is high. out_valid is low in the cycle after in_valid is low.
- R2: The flags out_inexact, out_underflow and out_overflow are low whenever out_valid is low. Each result's flags last only for that result's cycle.
- R3: rnd_mode encodes the rounding direction: 0 is nearest-even, 1 is toward zero, 2 is toward +inf, 3 is toward -inf. Rounding acts only when in_sig[2:0] (the bits below the kept significand) is nonzero, and then out_inexact is raised. Nearest adds 3 plus bit 3 of the significand. Toward +inf adds 8 for a positive sign only. Toward -inf adds 8 for a negative sign only. Toward zero adds nothing.
- R4: When rounding carries out of bit 26, the significand is shifted right by one and the exponent is incremented.
- R5: A normal result has the sign in bit 31, the biased exponent (exponent + 127) in bits 30..23, and the rounded significand bits 25..3 in bits 22..0.
- R6: Without flushing, an exponent below -126 shifts the significand right by (-126 - exponent), ORing the lost bits into bit 0, and sets the exponent to -126. If the bits below the kept significand are then nonzero while the hidden bit is clear, out_underflow and out_inexact are raised. A result whose hidden bit is clear after rounding is encoded with exponent field 0.
- R7: Without flushing, an exponent of exactly -127 whose rounding carries out of bit 26 gives the smallest normal number of that sign (exponent field 1, fraction 0). It raises out_inexact and does not raise out_underflow.
- R8: With flush_en high, an exponent below -126 raises out_underflow and out_inexact. The result is signed zero in modes 0 and 1. In mode 2 it is +smallest-subnormal for a positive sign and -0 for a negative sign. In mode 3 it is +0 for a positive sign and -smallest-subnormal for a negative sign.
- R9: When the exponent after rounding exceeds 127, out_overflow and out_inexact are raised. Mode 0 gives signed infinity. Mode 1 gives the signed largest finite value. Mode 2 gives +inf for a positive sign and the negative largest finite value for a negative sign. Mode 3 gives the positive largest finite value for a positive sign and -inf for a negative sign.
- R10: When uflow_trap_en is high, a result encoded with exponent field 0 raises out_underflow even if it is exact.
- R11: While rst_n is low, out_valid and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operand valid this cycle |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_sig | input | 27 | Hidden bit at 26, fraction 25..3, guard, round and sticky 2..0 |
| rnd_mode | input | 2 | Rounding direction (see R3) |
| flush_en | input | 1 | Replace tiny results by zero or the smallest subnormal |
| uflow_trap_en | input | 1 | Flag underflow on every subnormal result |
| out_valid | output | 1 | Result valid |
| out_word | output | 32 | Packed single-precision result |
| out_inexact | output | 1 | Result was rounded |
| out_underflow | output | 1 | Tiny result flag |
| out_overflow | output | 1 | Exponent overflow flag |

## Verification
The assertions rely on the operand being normalised: in_sig[26] is set whenever in_valid is high. They also rely on the exponent fitting the signed EXP_W range. Exact zeros, infinities and NaNs are never offered to the block. The stimulus always forces bit 26 of the significand. It draws exponents from about -200 to 200, which spans the deep-subnormal, edge and overflow regions while staying well inside the 10-bit default range. Flush and trap controls are mixed at random alongside directed corner operands.

// File: rtl/sp_rp_pkg.sv
package sp_rp_pkg;
    localparam int SIG_W  = 27;
    localparam int KEEP_W = 24;
    localparam int FRAC_W = 23;
    localparam int SP_EMIN = -126;
    localparam int SP_EMAX = 127;
    localparam int SP_BIAS = 127;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_UP   = 2'd2,
        RM_DOWN = 2'd3
    } rmode_e;

    typedef enum logic [1:0] {
        RK_NORMAL,
        RK_DENORM,
        RK_FLUSH,
        RK_OVF
    } rkind_e;

    typedef enum logic {
        ST_IDLE,
        ST_EMIT
    } pstate_e;
endpackage

// File: rtl/sp_rp_rounder.sv
module sp_rp_rounder
    import sp_rp_pkg::*;
(
    input  logic [SIG_W-1:0]  sig,
    input  logic              neg,
    input  rmode_e            mode,
    output logic [KEEP_W-1:0] kept,
    output logic              carry,
    output logic              inexact
);
    logic [3:0]        inc;
    logic              up3;
    logic [KEEP_W:0]   hi_sum;

    always_comb begin
        inexact = |sig[2:0];
        inc     = 4'd0;
        if (inexact) begin
            unique case (mode)
                RM_NEAR: inc = 4'd3 + {3'd0, sig[3]};
                RM_ZERO: inc = 4'd0;
                RM_UP:   inc = neg ? 4'd0 : 4'd8;
                RM_DOWN: inc = neg ? 4'd8 : 4'd0;
            endcase
        end
        up3    = ({1'b0, sig[2:0]} + inc) > 4'd7;
        hi_sum = {1'b0, sig[SIG_W-1:3]} + {{KEEP_W{1'b0}}, up3};
        carry  = hi_sum[KEEP_W];
        kept   = carry ? hi_sum[KEEP_W:1] : hi_sum[KEEP_W-1:0];
    end
endmodule

// File: rtl/sp_rp_sticky_shift.sv
module sp_rp_sticky_shift #(
    parameter int W  = 27,
    parameter int SW = 12
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] sh,
    output logic [W-1:0]  dout
);
    logic [W-1:0] kept;
    logic         lost;

    always_comb begin
        if (sh >= SW'(W)) begin
            kept = '0;
            lost = |din;
        end else begin
            kept = din >> sh;
            lost = |(din & ~({W{1'b1}} << sh));
        end
        dout = kept | {{(W-1){1'b0}}, lost};
    end
endmodule

// File: rtl/sp_round_pack.sv
module sp_round_pack
    import sp_rp_pkg::*;
#(
    parameter int EXP_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sign,
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [26:0]             in_sig,
    input  logic [1:0]              rnd_mode,
    input  logic                    flush_en,
    input  logic                    uflow_trap_en,
    output logic                    out_valid,
    output logic [31:0]             out_word,
    output logic                    out_inexact,
    output logic                    out_underflow,
    output logic                    out_overflow
);
    localparam int IW = EXP_W + 2;
    localparam logic signed [IW-1:0] EMIN_X = IW'(SP_EMIN);
    localparam logic signed [IW-1:0] EDGE_X = IW'(SP_EMIN - 1);
    localparam logic signed [IW-1:0] EMAX_X = IW'(SP_EMAX);
    localparam logic signed [IW-1:0] BIAS_X = IW'(SP_BIAS);

    pstate_e state_q, state_d;
    rmode_e  mode;

    logic signed [IW-1:0] xe, e1, e2;
    logic [IW-1:0]        sh_amt;
    logic                 tiny, do_flush, edge_hit;
    logic [SIG_W-1:0]     m_shift, m1;
    logic [KEEP_W-1:0]    pre_kept, m2;
    logic                 pre_carry, pre_ix, post_carry, post_ix;
    rkind_e               kind;
    logic [31:0]          word_d;
    logic                 ix_d, uf_d, ov_d;

    assign mode   = rmode_e'(rnd_mode);
    assign xe     = IW'(in_exp);
    assign tiny   = xe < EMIN_X;
    assign sh_amt = EMIN_X - xe;

    sp_rp_rounder i_pre_round (
        .sig(in_sig), .neg(in_sign), .mode(mode),
        .kept(pre_kept), .carry(pre_carry), .inexact(pre_ix)
    );

    sp_rp_sticky_shift #(.W(SIG_W), .SW(IW)) i_dn_shift (
        .din(in_sig), .sh(sh_amt), .dout(m_shift)
    );

    always_comb begin
        do_flush = tiny && flush_en;
        edge_hit = tiny && !flush_en && (xe == EDGE_X) && pre_ix && pre_carry;
        if (edge_hit) begin
            m1 = {pre_kept, 3'b000};
            e1 = EMIN_X;
        end else if (tiny) begin
            m1 = m_shift;
            e1 = EMIN_X;
        end else begin
            m1 = in_sig;
            e1 = xe;
        end
    end

    sp_rp_rounder i_post_round (
        .sig(m1), .neg(in_sign), .mode(mode),
        .kept(m2), .carry(post_carry), .inexact(post_ix)
    );

    always_comb begin
        e2 = e1 + {{(IW-1){1'b0}}, post_carry};
        if (do_flush)          kind = RK_FLUSH;
        else if (e2 > EMAX_X)  kind = RK_OVF;
        else if (!m2[KEEP_W-1]) kind = RK_DENORM;
        else                   kind = RK_NORMAL;
    end

    always_comb begin
        word_d = '0;
        ix_d   = post_ix | edge_hit;
        uf_d   = post_ix && !m1[SIG_W-1];
        ov_d   = 1'b0;
        unique case (kind)
            RK_FLUSH: begin
                word_d    = {in_sign, 31'd0};
                word_d[0] = (mode == RM_UP && !in_sign) || (mode == RM_DOWN && in_sign);
                ix_d      = 1'b1;
                uf_d      = 1'b1;
            end
            RK_OVF: begin
                if (mode == RM_NEAR || (mode == RM_UP && !in_sign) ||
                    (mode == RM_DOWN && in_sign))
                    word_d = {in_sign, 8'hFF, {FRAC_W{1'b0}}};
                else
                    word_d = {in_sign, 8'hFE, {FRAC_W{1'b1}}};
                ix_d = 1'b1;
                ov_d = 1'b1;
            end
            RK_DENORM: begin
                word_d = {in_sign, 8'd0, m2[FRAC_W-1:0]};
                uf_d   = uf_d | uflow_trap_en;
            end
            RK_NORMAL: begin
                word_d = {in_sign, 8'(e2 + BIAS_X), m2[FRAC_W-1:0]};
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word      <= '0;
            out_inexact   <= 1'b0;
            out_underflow <= 1'b0;
            out_overflow  <= 1'b0;
        end else if (in_valid) begin
            out_word      <= word_d;
            out_inexact   <= ix_d;
            out_underflow <= uf_d;
            out_overflow  <= ov_d;
        end else begin
            out_inexact   <= 1'b0;
            out_underflow <= 1'b0;
            out_overflow  <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_EMIT);
endmodule

// File: rtl/sp_round_pack_chk.sv
module sp_round_pack_chk #(
    parameter int EXP_W = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic signed [EXP_W-1:0] in_exp,
    input logic [26:0]             in_sig,
    input logic                    flush_en,
    input logic                    out_valid,
    input logic [31:0]             out_word,
    input logic                    out_inexact,
    input logic                    out_underflow,
    input logic                    out_overflow
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1

    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_inexact || out_underflow || out_overflow)); // R2

    AST_GRS_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sig[2:0] != 3'd0 && in_exp >= -126) |=> out_inexact); // R3

    AST_FLUSH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && flush_en && in_exp < -126) |=>
        (out_underflow && out_inexact && out_word[30:1] == 30'd0)); // R8

    AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
        out_overflow |-> out_inexact); // R9

    AST_OVF_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        out_overflow |-> (out_word[30:0] == 31'h7F800000 ||
                          out_word[30:0] == 31'h7F7FFFFF)); // R9
endmodule

bind sp_round_pack sp_round_pack_chk #(.EXP_W(EXP_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_exp(in_exp),
    .in_sig(in_sig), .flush_en(flush_en), .out_valid(out_valid),
    .out_word(out_word), .out_inexact(out_inexact),
    .out_underflow(out_underflow), .out_overflow(out_overflow)
);

// File: tb/test_sp_round_pack.sv
`timescale 1ns/1ps
module test_sp_round_pack;
    localparam int EXP_W = 10;

    typedef struct packed {
        logic [31:0] w;
        logic        ix;
        logic        uf;
        logic        ov;
        logic [7:0]  tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_sign = 1'b0;
    logic signed [EXP_W-1:0] in_exp = '0;
    logic [26:0] in_sig = 27'h4000000;
    logic [1:0] rnd_mode = 2'd0;
    logic flush_en = 1'b0;
    logic uflow_trap_en = 1'b0;
    logic out_valid;
    logic [31:0] out_word;
    logic out_inexact, out_underflow, out_overflow;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;
    exp_t expq[$];

    always #2 clk = ~clk;

    sp_round_pack #(.EXP_W(EXP_W)) i_sp_round_pack (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_exp(in_exp), .in_sig(in_sig), .rnd_mode(rnd_mode),
        .flush_en(flush_en), .uflow_trap_en(uflow_trap_en),
        .out_valid(out_valid), .out_word(out_word), .out_inexact(out_inexact),
        .out_underflow(out_underflow), .out_overflow(out_overflow)
    );

    function automatic int bm_round(bit s, int m, int mode);
        if ((m & 7) == 0) return m;
        case (mode)
            0: return m + 3 + ((m >> 3) & 1);
            2: return s ? m : m + 8;
            3: return s ? m + 8 : m;
            default: return m;
        endcase
    endfunction

    function automatic exp_t model(bit s, int e, int m, int mode, bit fl, bit tr, int tag);
        exp_t r;
        int x = m;
        int rr;
        int sh;
        r.tag = 8'(tag); r.ix = 0; r.uf = 0; r.ov = 0; r.w = 0;
        if (e < -126) begin
            if (fl) begin
                r.uf = 1; r.ix = 1;
                r.w = {s, 31'd0};
                if (mode == 2 && !s) r.w = 32'h00000001;
                if (mode == 3 && s)  r.w = 32'h80000001;
                return r;
            end
            rr = bm_round(s, x, mode);
            if (e == -127 && rr >= (1 << 27)) begin
                r.ix = 1;
                x = (rr >> 1) & ~7;
            end else begin
                sh = -126 - e;
                if (sh >= 27) x = 1;
                else x = (x >> sh) | (((x & ((1 << sh) - 1)) != 0) ? 1 : 0);
            end
            e = -126;
        end
        if ((x & 7) != 0) begin
            r.ix = 1;
            if (x < (1 << 26)) r.uf = 1;
            x = bm_round(s, x, mode);
            if (x >= (1 << 27)) begin
                x = x >> 1;
                e = e + 1;
            end
        end
        x = x >> 3;
        if (e > 127) begin
            r.ov = 1; r.ix = 1;
            if (mode == 0 || (mode == 2 && !s) || (mode == 3 && s))
                r.w = {s, 8'hFF, 23'd0};
            else
                r.w = {s, 8'hFE, 23'h7FFFFF};
            return r;
        end
        if (x < (1 << 23)) begin
            if (tr) r.uf = 1;
            r.w = {s, 8'd0, x[22:0]};
        end else begin
            r.w = {s, 8'(e + 127), x[22:0]};
        end
        return r;
    endfunction

    task automatic check(bit ok, int tag, string what, logic [31:0] got, logic [31:0] want);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s actual=%h expected=%h", tag, what, got, want);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic send(bit s, int e, int m, int mode, bit fl, bit tr, int tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_sign = s;
        in_exp = EXP_W'(e);
        in_sig = 27'(m);
        rnd_mode = 2'(mode);
        flush_en = fl;
        uflow_trap_en = tr;
        expq.push_back(model(s, e, m, mode, fl, tr, tag));
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: compares every cycle, a little after the rising edge
    always @(posedge clk) begin
        exp_t e;
        #1;
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
        if (!rst_n) begin
            // R11 reset state
            check(!out_valid && !out_inexact && !out_underflow && !out_overflow, 11,
                  "reset outputs", {28'd0, out_valid, out_inexact, out_underflow, out_overflow}, 32'd0);
        end else if (expq.size() > 0) begin
            e = expq.pop_front();
            check(out_valid, 1, "out_valid after in_valid", {31'd0, out_valid}, 32'd1); // R1
            check(out_word == e.w, int'(e.tag), "word", out_word, e.w);
            check({out_inexact, out_underflow, out_overflow} == {e.ix, e.uf, e.ov}, int'(e.tag),
                  "flags ix/uf/ov", {29'd0, out_inexact, out_underflow, out_overflow},
                  {29'd0, e.ix, e.uf, e.ov});
        end else begin
            check(!out_valid, 1, "out_valid idle", {31'd0, out_valid}, 32'd0); // R1
            // R2 flags quiet without a result
            check(!out_inexact && !out_underflow && !out_overflow, 2, "flags idle",
                  {29'd0, out_inexact, out_underflow, out_overflow}, 32'd0);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        // R5 exact normal values
        send(0, 0, 27'h4000000, 0, 0, 0, 5);
        send(1, -126, 27'h4000000, 1, 0, 0, 5);
        send(0, 127, 27'h5555550, 2, 0, 1, 5);
        // R3 nearest-even ties and each direction
        send(0, 3, 27'h4000004, 0, 0, 0, 3);
        send(0, 3, 27'h400000C, 0, 0, 0, 3);
        for (int md = 0; md < 4; md++) begin
            send(0, 10, 27'h4000001, md, 0, 0, 3);
            send(1, 10, 27'h4000001, md, 0, 0, 3);
        end
        idle(1);
        // R4 carry out of the significand
        send(0, 5, 27'h7FFFFFF, 0, 0, 0, 4);
        send(1, 5, 27'h7FFFFF9, 3, 0, 0, 4);
        // R7 not tiny after rounding
        send(0, -127, 27'h7FFFFFF, 0, 0, 0, 7);
        send(1, -127, 27'h7FFFFF9, 3, 0, 0, 7);
        send(0, -127, 27'h7FFFFF9, 3, 0, 0, 7);
        // R6 subnormal shifting
        send(0, -127, 27'h4000000, 0, 0, 0, 6);
        send(0, -130, 27'h4000013, 0, 0, 0, 6);
        send(0, -200, 27'h4000000, 0, 0, 0, 6);
        send(0, -200, 27'h4000000, 2, 0, 0, 6);
        send(1, -140, 27'h7FFFFFF, 1, 0, 0, 6);
        // R10 trap enable on exact subnormal
        send(0, -127, 27'h4000000, 0, 0, 1, 10);
        // R8 flush, every mode and sign
        for (int md = 0; md < 4; md++) begin
            send(0, -127, 27'h4000000, md, 1, 0, 8);
            send(1, -150, 27'h4123456, md, 1, 0, 8);
        end
        send(0, -126, 27'h4000001, 0, 1, 0, 8);
        // R9 overflow, every mode and sign
        for (int md = 0; md < 4; md++) begin
            send(0, 128, 27'h4000000, md, 0, 0, 9);
            send(1, 200, 27'h4000000, md, 0, 0, 9);
        end
        send(0, 127, 27'h7FFFFFF, 0, 0, 0, 9);
        idle(3);
        // mixed random operands
        for (int i = 0; i < 3000; i++) begin
            bit s = 1'($urandom);
            int e = int'($urandom % 400) - 200;
            int m = int'(27'h4000000 | ($urandom & 27'h3FFFFFF));
            int md = int'($urandom % 4);
            bit fl = (($urandom % 4) == 0);
            bit tr = 1'($urandom);
            int tag;
            if (($urandom % 3) == 0) m = m | 27'h3FFFFF8;
            if (e < -126) tag = fl ? 8 : 6;
            else if (e > 126) tag = 9;
            else tag = 3;
            send(s, e, m, md, fl, tr, tag);
            if (($urandom % 5) == 0) idle(1);
        end
        idle(4);
        finish_run();
    end
endmodule